// File: doc/BRIEF.md
# USB Device Bus Event and Suspend Monitor

This block watches bus-level events for a full-speed USB device and turns them into latched status bits and one interrupt request. An upstream packet decoder gives it three single-cycle strobes, one for any bus activity, one for each received start-of-frame packet and one for a bus reset. Two internal timers run from a shared microsecond-scale tick prescaler. One measures bus idle time and raises a suspend request after 3 ms of silence. The other expects a start-of-frame every 1 ms and flags each frame that does not arrive.

Software puts the device into low-power suspend with a one-cycle request. Any bus activity while suspended releases the low-power flag in the same cycle, without waiting for a clock edge. That activity also pulses a wake-up line and latches a resume status bit. The idle check is armed by a bus reset. It is disarmed on entry to low-power suspend and armed again by the first start-of-frame after the wake-up, which ends the resume sequence.

A mask register selects which status bits can raise the interrupt. A priority register enables two classes of endpoint events, isochronous and non-isochronous, and gives each class a 3-bit level. The block reports the level of the most urgent enabled class that is pending.

Top module: `usb_evt_mon`

## Requirements
- R1: After reset, status, mask and priority registers read 0, `irq_o`, `wake_o`, `lp_susp_o` and `addr_clr_o` are 0, and `irq_lvl_o` reads 7.
- R2: Status bit 3 (suspend request) sets once IDLE_TICKS ticks of TICK_DIV clocks pass with no activity while the idle check is armed. Any strobe restarts the count. One idle period sets the bit only once.
- R3: A bus-reset strobe sets status bit 2, pulses `addr_clr_o` for one cycle in the next cycle, and arms the idle check. The idle check is not armed before the first bus reset.
- R4: A `lp_set_i` pulse raises `lp_susp_o`. While the flag is high, neither the suspend request (bit 3) nor the missed-frame bit (bit 0) is set.
- R5: Any strobe while in low-power suspend drives `wake_o` high and `lp_susp_o` low in the same cycle and sets status bit 4 on the next edge. The idle check stays disarmed until the next start-of-frame strobe.
- R6: A start-of-frame strobe sets status bit 1.
- R7: Status bit 0 (missed frame) sets when FRAME_TICKS ticks pass without a start-of-frame. Each received start-of-frame reloads the frame timer.
- R8: A status write clears every bit written as 0 and keeps every bit written as 1. A hardware set in the same cycle wins over the clear.
- R9: `irq_o` is high whenever a status bit and its mask bit (same position, written through `mask_wr_i`) are both 1.
- R10: Priority register layout is [7] isochronous enable, [6:4] isochronous level, [3] non-isochronous enable, [2:0] non-isochronous level. An enabled, pending class raises `irq_o`. `irq_lvl_o` gives the smaller level of the enabled pending classes, with isochronous winning a tie, or 7 when no class is both enabled and pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| act_stb_i | input | 1 | Bus activity strobe |
| sof_stb_i | input | 1 | Start-of-frame received strobe |
| busrst_stb_i | input | 1 | Bus reset strobe |
| lp_set_i | input | 1 | Request to enter low-power suspend |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 5 | Status write data (0 clears) |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 5 | Mask write data |
| prio_wr_i | input | 1 | Priority register write strobe |
| prio_wdata_i | input | 8 | Priority register write data |
| iso_pend_i | input | 1 | Isochronous endpoint event pending |
| niso_pend_i | input | 1 | Non-isochronous endpoint event pending |
| stat_o | output | 5 | Status bits: 0 missed frame, 1 SOF, 2 bus reset, 3 suspend request, 4 resume |
| mask_o | output | 5 | Mask register |
| prio_o | output | 8 | Priority register |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 3 | Level of the winning endpoint class |
| wake_o | output | 1 | Wake-up line |
| lp_susp_o | output | 1 | Low-power suspend flag |
| addr_clr_o | output | 1 | Clear pulse for address and endpoint state |

## Verification
The assertions assume every strobe and write input is synchronous to the clock and one cycle wide. They also assume low-power suspend is entered only through `lp_set_i`, never in the same cycle as bus activity. The suspend-request property depends on this, because it relates a rising bit 3 to the low-power flag one cycle earlier. The stimulus drives all inputs on the falling edge as single-cycle pulses, keeps `lp_set_i` apart from every strobe, and leaves the timer windows slack by a full tick on each side, since the prescaler phase is not reset by activity.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int NST = 5;
  localparam int ST_MISS = 0;
  localparam int ST_SOF  = 1;
  localparam int ST_BRST = 2;
  localparam int ST_IDLE = 3;
  localparam int ST_WAKE = 4;

  localparam int PR_ISO_EN  = 7;
  localparam int PR_ISO_LO  = 4;
  localparam int PR_NISO_EN = 3;
  localparam int PR_NISO_LO = 0;
  localparam int LVL_W      = 3;

  typedef logic [NST-1:0] stat_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/usb_evt_timers.sv
module usb_evt_timers #(
  parameter int TICK_DIV    = 48,
  parameter int IDLE_TICKS  = 3000,
  parameter int FRAME_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_any_i,
  input  logic sof_i,
  input  logic idle_en_i,
  input  logic frame_en_i,
  output logic idle_hit_o,
  output logic frame_miss_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam int FW = $clog2(FRAME_TICKS + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          done_q, done_d;
  logic [FW-1:0] frm_q, frm_d;
  logic          tick;

  // shared tick prescaler
  always_comb begin
    tick  = (pre_q == PW'(TICK_DIV - 1));
    pre_d = tick ? '0 : pre_q + 1'b1;
  end

  // idle timer next state
  always_comb begin
    idle_d     = idle_q;
    done_d     = done_q;
    idle_hit_o = 1'b0;
    if (act_any_i || !idle_en_i) begin
      idle_d = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (idle_q == IW'(IDLE_TICKS - 1)) begin
        idle_hit_o = 1'b1;
        done_d     = 1'b1;
        idle_d     = '0;
      end else begin
        idle_d = idle_q + 1'b1;
      end
    end
  end

  // frame timer next state
  always_comb begin
    frm_d        = frm_q;
    frame_miss_o = 1'b0;
    if (sof_i || !frame_en_i) begin
      frm_d = '0;
    end else if (tick) begin
      if (frm_q == FW'(FRAME_TICKS - 1)) begin
        frame_miss_o = 1'b1;
        frm_d        = '0;
      end else begin
        frm_d = frm_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      idle_q <= '0;
      done_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      pre_q  <= pre_d;
      idle_q <= idle_d;
      done_q <= done_d;
      frm_q  <= frm_d;
    end
  end
endmodule

// File: rtl/usb_evt_stat.sv
module usb_evt_stat
  import usb_evt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  act_any_i,
  input  logic  sof_i,
  input  logic  busrst_i,
  input  logic  idle_hit_i,
  input  logic  frame_miss_i,
  input  logic  lp_set_i,
  input  logic  wr_i,
  input  stat_t wdata_i,
  output stat_t stat_o,
  output logic  lp_o,
  output logic  wake_o,
  output logic  idle_en_o,
  output logic  frame_en_o,
  output logic  addr_clr_o
);
  logic  lp_q, lp_d;
  logic  arm_q, arm_d;
  logic  rsm_q, rsm_d;
  logic  clr_q;
  stat_t set_vec;

  // wake path is combinational: flag drops in the cycle of the activity
  always_comb begin
    wake_o     = lp_q & act_any_i;
    lp_o       = lp_q & ~act_any_i;
    idle_en_o  = arm_q & ~lp_q;
    frame_en_o = ~lp_q;
  end

  always_comb begin
    lp_d  = lp_q;
    arm_d = arm_q;
    rsm_d = rsm_q;
    if (wake_o) begin
      lp_d  = 1'b0;
      rsm_d = 1'b1;
    end else if (lp_set_i) begin
      lp_d = 1'b1;
    end
    if (busrst_i) begin
      arm_d = 1'b1;
      rsm_d = 1'b0;
    end else if (lp_set_i && !wake_o) begin
      arm_d = 1'b0;
    end else if (rsm_q && sof_i) begin
      arm_d = 1'b1;
      rsm_d = 1'b0;
    end
  end

  always_comb begin
    set_vec          = '0;
    set_vec[ST_MISS] = frame_miss_i;
    set_vec[ST_SOF]  = sof_i;
    set_vec[ST_BRST] = busrst_i;
    set_vec[ST_IDLE] = idle_hit_i;
    set_vec[ST_WAKE] = wake_o;
  end

  for (genvar b = 0; b < NST; b++) begin : g_bit
    logic bit_q, bit_d, bit_en;
    always_comb begin
      bit_en = set_vec[b] | (wr_i & ~wdata_i[b]);
      bit_d  = set_vec[b];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end
    assign stat_o[b] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q  <= 1'b0;
      arm_q <= 1'b0;
      rsm_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      lp_q  <= lp_d;
      arm_q <= arm_d;
      rsm_q <= rsm_d;
      clr_q <= busrst_i;
    end
  end

  assign addr_clr_o = clr_q;
endmodule

// File: rtl/usb_evt_irq.sv
module usb_evt_irq
  import usb_evt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  stat_t      stat_i,
  input  logic       mask_wr_i,
  input  stat_t      mask_wdata_i,
  input  logic       prio_wr_i,
  input  logic [7:0] prio_wdata_i,
  input  logic       iso_pend_i,
  input  logic       niso_pend_i,
  output stat_t      mask_o,
  output logic [7:0] prio_o,
  output logic       irq_o,
  output lvl_t       lvl_o
);
  stat_t      mask_q;
  logic [7:0] prio_q;
  logic       iso_req, niso_req;
  lvl_t       iso_lvl, niso_lvl;

  always_comb begin
    iso_lvl  = prio_q[PR_ISO_LO +: LVL_W];
    niso_lvl = prio_q[PR_NISO_LO +: LVL_W];
    iso_req  = prio_q[PR_ISO_EN] & iso_pend_i;
    niso_req = prio_q[PR_NISO_EN] & niso_pend_i;
    if (iso_req && niso_req) lvl_o = (iso_lvl <= niso_lvl) ? iso_lvl : niso_lvl;
    else if (iso_req)        lvl_o = iso_lvl;
    else if (niso_req)       lvl_o = niso_lvl;
    else                     lvl_o = '1;
    irq_o = (|(stat_i & mask_q)) | iso_req | niso_req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prio_q <= '0;
    else if (prio_wr_i) prio_q <= prio_wdata_i;
  end

  assign mask_o = mask_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/usb_evt_mon.sv
module usb_evt_mon
  import usb_evt_pkg::*;
#(
  parameter int TICK_DIV    = 48,
  parameter int IDLE_TICKS  = 3000,
  parameter int FRAME_TICKS = 1000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           act_stb_i,
  input  logic           sof_stb_i,
  input  logic           busrst_stb_i,
  input  logic           lp_set_i,
  input  logic           stat_wr_i,
  input  logic [NST-1:0] stat_wdata_i,
  input  logic           mask_wr_i,
  input  logic [NST-1:0] mask_wdata_i,
  input  logic           prio_wr_i,
  input  logic [7:0]     prio_wdata_i,
  input  logic           iso_pend_i,
  input  logic           niso_pend_i,
  output logic [NST-1:0] stat_o,
  output logic [NST-1:0] mask_o,
  output logic [7:0]     prio_o,
  output logic           irq_o,
  output logic [2:0]     irq_lvl_o,
  output logic           wake_o,
  output logic           lp_susp_o,
  output logic           addr_clr_o
);
  logic [1:0] rsync_q;
  logic       rst_n;
  logic       act_any, idle_en, frame_en, idle_hit, frame_miss;
  stat_t      stat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n   = rsync_q[1];
  assign act_any = act_stb_i | sof_stb_i | busrst_stb_i;

  usb_evt_timers #(
    .TICK_DIV    (TICK_DIV),
    .IDLE_TICKS  (IDLE_TICKS),
    .FRAME_TICKS (FRAME_TICKS)
  ) i_timers (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .act_any_i    (act_any),
    .sof_i        (sof_stb_i),
    .idle_en_i    (idle_en),
    .frame_en_i   (frame_en),
    .idle_hit_o   (idle_hit),
    .frame_miss_o (frame_miss)
  );

  usb_evt_stat i_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .act_any_i    (act_any),
    .sof_i        (sof_stb_i),
    .busrst_i     (busrst_stb_i),
    .idle_hit_i   (idle_hit),
    .frame_miss_i (frame_miss),
    .lp_set_i     (lp_set_i),
    .wr_i         (stat_wr_i),
    .wdata_i      (stat_wdata_i),
    .stat_o       (stat),
    .lp_o         (lp_susp_o),
    .wake_o       (wake_o),
    .idle_en_o    (idle_en),
    .frame_en_o   (frame_en),
    .addr_clr_o   (addr_clr_o)
  );

  usb_evt_irq i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .stat_i       (stat),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .prio_wr_i    (prio_wr_i),
    .prio_wdata_i (prio_wdata_i),
    .iso_pend_i   (iso_pend_i),
    .niso_pend_i  (niso_pend_i),
    .mask_o       (mask_o),
    .prio_o       (prio_o),
    .irq_o        (irq_o),
    .lvl_o        (irq_lvl_o)
  );

  assign stat_o = stat;
endmodule

// File: rtl/usb_evt_mon_chk.sv
module usb_evt_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       act_stb_i,
  input logic       sof_stb_i,
  input logic       busrst_stb_i,
  input logic       stat_wr_i,
  input logic [4:0] stat_wdata_i,
  input logic       iso_pend_i,
  input logic       niso_pend_i,
  input logic [4:0] stat_o,
  input logic [4:0] mask_o,
  input logic [7:0] prio_o,
  input logic       irq_o,
  input logic [2:0] irq_lvl_o,
  input logic       wake_o,
  input logic       lp_susp_o,
  input logic       addr_clr_o
);
  logic act_any;
  assign act_any = act_stb_i | sof_stb_i | busrst_stb_i;

  p_sof_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_stb_i |=> stat_o[1]);

  p_busrst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busrst_stb_i |=> (stat_o[2] && addr_clr_o));

  p_sw_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !stat_wdata_i[1] && !sof_stb_i) |=> !stat_o[1]);

  p_wake_now_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lp_susp_o) && act_any) |-> (wake_o && !lp_susp_o));

  p_wake_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> (stat_o[4] && !lp_susp_o));

  p_no_susp_in_lp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[3]) |-> !$past(lp_susp_o));

  p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_o == 5'd0) && !prio_o[7] && !prio_o[3]) |-> !irq_o);

  p_lvl_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(prio_o[7] && iso_pend_i) && !(prio_o[3] && niso_pend_i)) |-> (irq_lvl_o == 3'd7));
endmodule

bind usb_evt_mon usb_evt_mon_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .act_stb_i    (act_stb_i),
  .sof_stb_i    (sof_stb_i),
  .busrst_stb_i (busrst_stb_i),
  .stat_wr_i    (stat_wr_i),
  .stat_wdata_i (stat_wdata_i),
  .iso_pend_i   (iso_pend_i),
  .niso_pend_i  (niso_pend_i),
  .stat_o       (stat_o),
  .mask_o       (mask_o),
  .prio_o       (prio_o),
  .irq_o        (irq_o),
  .irq_lvl_o    (irq_lvl_o),
  .wake_o       (wake_o),
  .lp_susp_o    (lp_susp_o),
  .addr_clr_o   (addr_clr_o)
);

// File: tb/test_usb_evt_mon.sv
`timescale 1ns/1ps
module test_usb_evt_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act = 1'b0, sof = 1'b0, brst = 1'b0, lpset = 1'b0;
  logic       swr = 1'b0, mwr = 1'b0, pwr = 1'b0;
  logic [4:0] swd = '0, mwd = '0;
  logic [7:0] pwd = '0;
  logic       isop = 1'b0, nisop = 1'b0;
  logic [4:0] stat, mask;
  logic [7:0] prio;
  logic       irq, wake, lp, aclr;
  logic [2:0] lvl;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  usb_evt_mon #(.TICK_DIV(4), .IDLE_TICKS(12), .FRAME_TICKS(8)) i_usb_evt_mon (
    .clk_i(clk), .rst_ni(rst_n), .act_stb_i(act), .sof_stb_i(sof),
    .busrst_stb_i(brst), .lp_set_i(lpset), .stat_wr_i(swr), .stat_wdata_i(swd),
    .mask_wr_i(mwr), .mask_wdata_i(mwd), .prio_wr_i(pwr), .prio_wdata_i(pwd),
    .iso_pend_i(isop), .niso_pend_i(nisop), .stat_o(stat), .mask_o(mask),
    .prio_o(prio), .irq_o(irq), .irq_lvl_o(lvl), .wake_o(wake),
    .lp_susp_o(lp), .addr_clr_o(aclr));

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_brst(); @(negedge clk); brst = 1'b1; @(negedge clk); brst = 1'b0; endtask
  task automatic pulse_sof();  @(negedge clk); sof = 1'b1;  @(negedge clk); sof = 1'b0;  endtask
  task automatic pulse_act();  @(negedge clk); act = 1'b1;  @(negedge clk); act = 1'b0;  endtask
  task automatic wr_stat(input logic [4:0] d);
    @(negedge clk); swr = 1'b1; swd = d; @(negedge clk); swr = 1'b0;
  endtask
  task automatic wr_mask(input logic [4:0] d);
    @(negedge clk); mwr = 1'b1; mwd = d; @(negedge clk); mwr = 1'b0;
  endtask
  task automatic wr_prio(input logic [7:0] d);
    @(negedge clk); pwr = 1'b1; pwd = d; @(negedge clk); pwr = 1'b0;
  endtask

  task automatic t_reset();
    chk(stat == 5'd0, "R1 stat", stat, 0);
    chk(mask == 5'd0, "R1 mask", mask, 0);
    chk(prio == 8'd0, "R1 prio", prio, 0);
    chk(irq == 1'b0 && wake == 1'b0 && lp == 1'b0 && aclr == 1'b0, "R1 outputs",
        {irq, wake, lp, aclr}, 0);
    chk(lvl == 3'd7, "R10 idle level", lvl, 7);
  endtask

  task automatic t_unarmed();
    wr_stat(5'd0);
    cyc(70);
    chk(stat[3] == 1'b0, "R3 idle check unarmed before bus reset", stat[3], 0);
  endtask

  task automatic t_busrst();
    @(negedge clk); brst = 1'b1;
    @(negedge clk); brst = 1'b0;
    chk(stat[2] == 1'b1, "R3 reset bit", stat[2], 1);
    chk(aclr == 1'b1, "R3 clear pulse high", aclr, 1);
    @(negedge clk);
    chk(aclr == 1'b0, "R3 clear pulse one cycle", aclr, 0);
  endtask

  task automatic t_idle();
    wr_stat(5'd0);
    cyc(30);
    pulse_act();
    cyc(40);
    chk(stat[3] == 1'b0, "R2 activity restarts idle count", stat[3], 0);
    cyc(12);
    chk(stat[3] == 1'b1, "R2 suspend request after idle", stat[3], 1);
    wr_stat(5'd0);
    cyc(60);
    chk(stat[3] == 1'b0, "R2 one set per idle period", stat[3], 0);
  endtask

  task automatic t_frames();
    pulse_sof();
    wr_stat(5'd0);
    for (int i = 0; i < 4; i++) begin
      cyc(18);
      pulse_sof();
    end
    chk(stat[1] == 1'b1, "R6 sof bit", stat[1], 1);
    chk(stat[0] == 1'b0, "R7 no miss while frames arrive", stat[0], 0);
    cyc(40);
    chk(stat[0] == 1'b1, "R7 missed frame flagged", stat[0], 1);
  endtask

  task automatic t_lowpower();
    pulse_brst();
    @(negedge clk); lpset = 1'b1;
    @(negedge clk); lpset = 1'b0;
    chk(lp == 1'b1, "R4 low-power flag set", lp, 1);
    wr_stat(5'd0);
    cyc(70);
    chk(stat[3] == 1'b0, "R4 no suspend request in low power", stat[3], 0);
    chk(stat[0] == 1'b0, "R4 no missed frame in low power", stat[0], 0);
    @(negedge clk); act = 1'b1;
    #1;
    chk(wake == 1'b1, "R5 wake same cycle", wake, 1);
    chk(lp == 1'b0, "R5 flag drops same cycle", lp, 0);
    @(negedge clk); act = 1'b0;
    chk(stat[4] == 1'b1, "R5 resume bit", stat[4], 1);
    chk(lp == 1'b0 && wake == 1'b0, "R5 settled after wake", {lp, wake}, 0);
    wr_stat(5'd0);
    cyc(70);
    chk(stat[3] == 1'b0, "R5 idle check off until sof", stat[3], 0);
    pulse_sof();
    wr_stat(5'd0);
    cyc(60);
    chk(stat[3] == 1'b1, "R5 idle check rearmed by sof", stat[3], 1);
  endtask

  task automatic t_swclear();
    pulse_sof();
    wr_stat(5'b00010);
    chk(stat[1] == 1'b1, "R8 write 1 keeps bit", stat[1], 1);
    wr_stat(5'b00000);
    chk(stat[1] == 1'b0, "R8 write 0 clears bit", stat[1], 0);
    @(negedge clk); sof = 1'b1; swr = 1'b1; swd = 5'd0;
    @(negedge clk); sof = 1'b0; swr = 1'b0;
    chk(stat[1] == 1'b1, "R8 hardware set wins", stat[1], 1);
  endtask

  task automatic t_irq();
    wr_mask(5'b00010);
    chk(mask == 5'b00010, "R9 mask readback", mask, 2);
    pulse_sof();
    chk(irq == 1'b1, "R9 unmasked bit raises irq", irq, 1);
    wr_stat(5'd0);
    chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);
    pulse_sof();
    wr_mask(5'd0);
    chk(irq == 1'b0, "R9 masked bit gives no irq", irq, 0);
  endtask

  task automatic t_endpoint();
    wr_prio(8'hDA);
    chk(prio == 8'hDA, "R10 prio readback", prio, 8'hDA);
    @(negedge clk); isop = 1'b1; #1;
    chk(irq == 1'b1 && lvl == 3'd5, "R10 iso level", {irq, lvl}, {1'b1, 3'd5});
    @(negedge clk); nisop = 1'b1; #1;
    chk(lvl == 3'd2, "R10 smaller level wins", lvl, 2);
    wr_prio(8'h9E); #1;
    chk(lvl == 3'd1, "R10 iso more urgent", lvl, 1);
    wr_prio(8'h1E);
    @(negedge clk); nisop = 1'b0; #1;
    chk(irq == 1'b0 && lvl == 3'd7, "R10 disabled class ignored", {irq, lvl}, 7);
    @(negedge clk); isop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_unarmed();
    t_busrst();
    t_idle();
    t_frames();
    t_lowpower();
    t_swclear();
    t_irq();
    t_endpoint();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule